// File: doc/BRIEF.md
# Sector Blank Check Engine

This block holds a small word-organised memory array split into equal sectors and, on request, scans one chosen sector to confirm that every word in it still holds the erased pattern (all ones). A one-cycle start pulse with a sector number begins a scan. The request is taken only when the engine is idle and the surrounding controller reports that no program, erase or suspend operation is active.

While the scan runs, the engine reads one word per clock and stops on the first word that is not all ones. An 8-bit status byte reports progress and outcome. Bit 7 reads 0 while the scan is running and 1 when the engine is ready. Bit 5 reads 1 when the last scan found a word that is not erased, and 0 otherwise. While the scan runs, host reads of the array return a fixed garbage value and host writes are dropped. When the scan finishes, the engine returns to idle.

Top module: `blank_check_engine`

## Requirements
- R1: After reset the status byte reads 8'h80 (bit 7 ready = 1, bit 5 not-blank = 0), and every array word reads 16'hFFFF.
- R2: A start pulse that arrives while `op_active` is 1 is ignored. Status bit 7 stays 1 and no scan begins.
- R3: A start pulse that arrives during a running scan is ignored. The scan neither restarts nor changes its length.
- R4: On the clock edge that accepts a start, status bit 7 falls to 0 and bit 5 clears to 0. Bit 7 stays 0 until the scan ends.
- R5: A scan of a sector whose words are all 16'hFFFF ends after exactly SECTOR_WORDS clock edges following the accepting edge. At that point bit 7 returns to 1 and bit 5 is 0.
- R6: If the first word that is not 16'hFFFF sits at offset k, the scan ends after exactly k+1 clock edges following the accepting edge, with bit 5 = 1.
- R7: Only the selected sector is scanned. The array address is {sector, offset}, and dirty words in other sectors do not affect the result.
- R8: While a scan runs, `host_rd_data` returns GARBAGE (default 16'hDEAD). When idle, it returns the stored word at `host_rd_addr`.
- R9: Host writes issued during a scan are discarded. Host writes issued while idle store the data.
- R10: Status bit 5 holds its result after a scan, through idle cycles, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bc_start | input | 1 | One-cycle blank-check request |
| bc_sector | input | SEC_W | Sector to scan |
| op_active | input | 1 | Program, erase or suspend in progress elsewhere |
| host_rd_addr | input | ADDR_W | Host read address {sector, offset} |
| host_rd_data | output | DATA_W | Host read data, or GARBAGE during a scan |
| host_wr_en | input | 1 | Host word write strobe |
| host_wr_addr | input | ADDR_W | Host write address |
| host_wr_data | input | DATA_W | Host write data |
| status | output | 8 | Bit 7 ready, bit 5 not-blank, other bits 0 |

## Verification
Scans are run against several sector contents:
- A fully erased sector, which measures the full-length scan.
- A dirty word at offset 0, which tests the earliest stop.
- A dirty word at the last offset, which separates "scanned to the end and found dirt" from "clean".
- A dirty word in the middle, which tests that the cycle count tracks the offset.
- Single-bit and all-zero dirty values, which show that any cleared bit is detected.

A dirty word placed in a neighbouring sector shows that the sector field steers the address. Blocked starts, repeated starts and host accesses during a scan show that stimulus outside the idle window leaves the outputs unchanged.

// File: rtl/bc_pkg.sv
package bc_pkg;
    typedef enum logic {ST_IDLE, ST_SCAN} bc_state_e;
    localparam int STAT_RDY_BIT = 7;
    localparam int STAT_NB_BIT  = 5;
endpackage

// File: rtl/bc_array.sv
module bc_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];
endmodule

// File: rtl/bc_scan.sv
module bc_scan
    import bc_pkg::*;
#(
    parameter int SEC_W  = 2,
    parameter int OFF_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SEC_W-1:0]       sector,
    input  logic                   blocked,
    input  logic [DATA_W-1:0]      word,
    output logic [SEC_W+OFF_W-1:0] scan_addr,
    output logic                   busy,
    output logic                   ready,
    output logic                   not_blank
);
    localparam logic [OFF_W-1:0]  LAST = '1;
    localparam logic [DATA_W-1:0] ONES = '1;

    typedef struct packed {
        bc_state_e        state;
        logic [SEC_W-1:0] sec;
        logic [OFF_W-1:0] idx;
        logic             rdy;
        logic             nb;
    } scan_t;

    scan_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start && !blocked) begin
                    d.state = ST_SCAN;
                    d.sec   = sector;
                    d.idx   = '0;
                    d.rdy   = 1'b0;
                    d.nb    = 1'b0;
                end
            end
            ST_SCAN: begin
                if (word != ONES) begin
                    d.state = ST_IDLE;
                    d.rdy   = 1'b1;
                    d.nb    = 1'b1;
                end else if (q.idx == LAST) begin
                    d.state = ST_IDLE;
                    d.rdy   = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.sec   <= '0;
            q.idx   <= '0;
            q.rdy   <= 1'b1;
            q.nb    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign scan_addr = {q.sec, q.idx};
    assign busy      = (q.state == ST_SCAN);
    assign ready     = q.rdy;
    assign not_blank = q.nb;

    AST_BLOCKED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && blocked && !busy) |=> !busy); // R2
    AST_STEADY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (q.idx == OFF_W'($past(q.idx) + 1'b1))); // R3
    AST_READY_LOW_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready); // R4
    AST_CLEAN_END_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !not_blank) |-> ($past(q.idx) == LAST)); // R5
    AST_DIRTY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(not_blank) |-> ($past(word) != ONES)); // R6
endmodule

// File: rtl/blank_check_engine.sv
module blank_check_engine
    import bc_pkg::*;
#(
    parameter int          NUM_SECTORS  = 4,
    parameter int          SECTOR_WORDS = 64,
    parameter int          DATA_W       = 16,
    parameter logic [15:0] GARBAGE      = 16'hDEAD,
    localparam int         SEC_W        = $clog2(NUM_SECTORS),
    localparam int         OFF_W        = $clog2(SECTOR_WORDS),
    localparam int         ADDR_W       = SEC_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bc_start,
    input  logic [SEC_W-1:0]  bc_sector,
    input  logic              op_active,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic [7:0]        status
);
    localparam logic [DATA_W-1:0] JUNK = DATA_W'(GARBAGE);

    logic [ADDR_W-1:0] scan_addr;
    logic [DATA_W-1:0] scan_word;
    logic [DATA_W-1:0] host_word;
    logic              busy, ready, not_blank;

    bc_array #(.DATA_W(DATA_W), .DEPTH(NUM_SECTORS * SECTOR_WORDS), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en && !busy),
        .wr_addr (host_wr_addr),
        .wr_data (host_wr_data),
        .ra_addr (scan_addr),
        .ra_data (scan_word),
        .rb_addr (host_rd_addr),
        .rb_data (host_word)
    );

    bc_scan #(.SEC_W(SEC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bc_start),
        .sector    (bc_sector),
        .blocked   (op_active),
        .word      (scan_word),
        .scan_addr (scan_addr),
        .busy      (busy),
        .ready     (ready),
        .not_blank (not_blank)
    );

    assign host_rd_data = busy ? JUNK : host_word;

    always_comb begin
        status               = 8'h00;
        status[STAT_RDY_BIT] = ready;
        status[STAT_NB_BIT]  = not_blank;
    end

    AST_JUNK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !status[STAT_RDY_BIT] |-> (host_rd_data == JUNK)); // R8
endmodule

// File: tb/sim_blank_check_engine.sv
`timescale 1ns/1ps
module sim_blank_check_engine;
    localparam int NV = 6;
    // {sector[1:0], plant, offset[5:0], value[15:0], blocked, exp_nb, exp_cycles[7:0]}
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 1'b0, 6'd0,  16'hFFFF, 1'b0, 1'b0, 8'd64},  // R5 clean
        {2'd1, 1'b1, 6'd0,  16'h0000, 1'b0, 1'b1, 8'd1},   // R6 first word
        {2'd2, 1'b1, 6'd63, 16'hFFFE, 1'b0, 1'b1, 8'd64},  // R6 last word
        {2'd3, 1'b1, 6'd17, 16'h7FFF, 1'b0, 1'b1, 8'd18},  // R6 middle
        {2'd1, 1'b0, 6'd0,  16'hFFFF, 1'b1, 1'b0, 8'd0},   // R2 blocked
        {2'd2, 1'b1, 6'd40, 16'hFBFF, 1'b0, 1'b1, 8'd41}   // R6 one bit
    };

    logic        clk = 0, rst_n = 0;
    logic        bc_start = 0, op_active = 0, host_wr_en = 0;
    logic [1:0]  bc_sector = 0;
    logic [7:0]  host_rd_addr = 0, host_wr_addr = 0;
    logic [15:0] host_wr_data = 0;
    logic [15:0] host_rd_data;
    logic [7:0]  status;
    int nchk = 0, nfail = 0, cyc = 0;

    always #10 clk = ~clk;

    blank_check_engine u0 (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        host_wr_en = 1; host_wr_addr = a; host_wr_data = v;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    // Returns edges after accepting edge until ready; 999 on timeout.
    task automatic run_scan(input logic [1:0] s, input bit blk, output int n);
        @(negedge clk);
        bc_start = 1; bc_sector = s; op_active = blk;
        @(negedge clk);
        bc_start = 0; op_active = 0;
        n = 0;
        while (status[7] == 1'b0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (n >= 300) n = 999;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nfail++;
                $display("FAIL watchdog");
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
                $finish;
            end
        end
    end

    initial begin
        int n;
        logic [1:0] s;
        logic [5:0] off;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(status == 8'h80, "R1 status", status, 8'h80);
        host_rd_addr = 8'd77; #1;
        check(host_rd_data == 16'hFFFF, "R1 array", host_rd_data, 16'hFFFF);

        for (int i = 0; i < NV; i++) begin
            s = VEC[i][34:33]; off = VEC[i][31:26];
            if (VEC[i][32]) hwrite({s, off}, VEC[i][25:10]);
            run_scan(s, VEC[i][9], n);
            if (VEC[i][9]) begin
                check(n == 0 && status[7], "R2 blocked start", n, 0);
            end else begin
                check(n == int'(VEC[i][7:0]), "R5/R6 cycles", n, VEC[i][7:0]);
                check(status[5] == VEC[i][8], "R5/R6 bit5", status[5], VEC[i][8]);
            end
            if (VEC[i][32]) hwrite({s, off}, 16'hFFFF);
        end

        // R7: dirt in sector 1 does not affect a scan of sector 0
        hwrite({2'd1, 6'd5}, 16'h0000);
        run_scan(2'd0, 1'b0, n);
        check(n == 64 && !status[5], "R7 other sector", n, 64);
        run_scan(2'd1, 1'b0, n);
        check(n == 6 && status[5], "R7 selected sector", n, 6);

        // R10: bit5 holds after idle cycles
        repeat (5) @(negedge clk);
        check(status == 8'hA0, "R10 hold", status, 8'hA0);
        hwrite({2'd1, 6'd5}, 16'hFFFF);

        // R4, R8, R9, R3 during one scan of blank sector 2
        @(negedge clk);
        bc_start = 1; bc_sector = 2'd2;
        @(negedge clk);
        bc_start = 0;
        check(status == 8'h00, "R4 R10 cleared at start", status, 8'h00);
        host_rd_addr = {2'd3, 6'd9}; #1;
        check(host_rd_data == 16'hDEAD, "R8 garbage", host_rd_data, 16'hDEAD);
        host_wr_en = 1; host_wr_addr = {2'd3, 6'd9}; host_wr_data = 16'h1234;
        @(negedge clk);
        host_wr_en = 0;
        bc_start = 1; bc_sector = 2'd1;  // R3 restart attempt
        @(negedge clk);
        bc_start = 0;
        n = 2;
        while (status[7] == 1'b0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        check(n == 64, "R3 no restart", n, 64);
        check(status[5] == 1'b0, "R3 result", status[5], 0);
        #1;
        check(host_rd_data == 16'hFFFF, "R9 write dropped / R8 idle read", host_rd_data, 16'hFFFF);
        hwrite({2'd3, 6'd9}, 16'h1234);
        #1;
        check(host_rd_data == 16'h1234, "R9 idle write", host_rd_data, 16'h1234);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule